// File: doc/BRIEF.md
# Programmable high/low phase clock divider

This block derives an output clock from its parent clock. Two separately programmed phase lengths set how many parent cycles the output spends high and how many it spends low, so the duty cycle can be asymmetric. A divider enable bit selects between this counting mode and a bypass in which the parent clock itself is passed on. A gate bit turns the output on or off. A build parameter can remove the gate, and the output is then always on.

Settings are loaded through a one-cycle write port with two targets: the control word (enable, high length, low length) and the gate word. Counting settings written while the divider runs are held in shadow storage and copied into the active counter only when the current low phase ends. Gate changes are applied only while the output is low. Neither kind of change can therefore shorten a pulse or produce a runt.

Top module: `phase_clk_div`

## Requirements
- R1: After reset the divider is in bypass, both phase fields are 0 and the gate is off, so `clk_o` is low in both halves of every parent cycle until the gate is set.
- R2: While the active enable bit (control word bit `EN_POS`, default 31) is 0, `clk_o` equals the parent clock when gated on, whatever the phase fields hold.
- R3: With the divider enabled, `clk_o` stays high for H+1 parent cycles, where H is the control word field at `HI_POS` of width `HI_W` (default bits 7:0).
- R4: With the divider enabled, `clk_o` stays low for L+1 parent cycles, where L is the control word field at `LO_POS` of width `LO_W` (default bits 13:8).
- R5: One output period lasts (H+1)+(L+1) parent cycles, and H=L=0 gives divide-by-2 with 50% duty.
- R6: A control word written while the divider runs takes effect only after the current low phase has completed. The phase lengths in progress are unchanged.
- R7: Writing the control word with the enable bit set while in bypass starts a high phase. `clk_o` is high from the second rising edge after the write cycle.
- R8: The gate bit (gate word, `wr_sel_i`=1, bit `GATE_POS`, default 0) lets the output through when 1 and forces it low when 0. A new gate value is applied only at a rising edge where the divided output is low, or at any edge in bypass.
- R9: A gate word write leaves the enable, high and low settings unchanged.
- R10: With `HAS_GATE`=0 the output is always enabled, including after reset, and gate word writes have no effect.
- R11: Clearing the enable bit while the divider runs returns the block to bypass only after the current low phase has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 gate word |
| wr_data_i | input | DATA_W | Write data |
| clk_o | output | 1 | Divided, bypassed or gated output clock |

## Verification
The bench builds two copies side by side from the same write stimulus. One uses the default layout with the gate present. The other sets `HAS_GATE`=0, which makes the always-on output and the ignored gate writes observable at the same moments the gated copy turns off. The unequal 8-bit high and 6-bit low fields allow the widest settings, 256 high and 64 low cycles, to be measured. These widths also confirm that the two counts do not share a width, so settings at each field's maximum can be checked.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_GATE = 1'b1
  } wr_sel_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EN_POS   = 31,
  parameter int unsigned HI_POS   = 0,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned LO_POS   = 8,
  parameter int unsigned LO_W     = 6,
  parameter int unsigned GATE_POS = 0,
  parameter bit          HAS_GATE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_sh_o,
  output logic [HI_W-1:0]   hi_sh_o,
  output logic [LO_W-1:0]   lo_sh_o,
  output logic              gate_sh_o
);
  logic            ctrl_we;
  logic            en_d, en_q;
  logic [HI_W-1:0] hi_d, hi_q;
  logic [LO_W-1:0] lo_d, lo_q;

  assign ctrl_we = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CTRL);

  always_comb begin
    en_d = wr_data_i[EN_POS];
    hi_d = wr_data_i[HI_POS +: HI_W];
    lo_d = wr_data_i[LO_POS +: LO_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (ctrl_we) begin
      en_q <= en_d;
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  generate
    if (HAS_GATE) begin : g_gate_reg
      logic gate_we;
      logic gate_d, gate_q;
      assign gate_we = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_GATE);
      assign gate_d  = wr_data_i[GATE_POS];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      gate_q <= 1'b0;
        else if (gate_we) gate_q <= gate_d;
      end
      assign gate_sh_o = gate_q;
    end else begin : g_gate_none
      assign gate_sh_o = 1'b1;
    end
  endgenerate

  assign en_sh_o = en_q;
  assign hi_sh_o = hi_q;
  assign lo_sh_o = lo_q;

  // R9: a gate word write must not disturb the divider settings
  a_r9_gate_keeps_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> ($stable(en_q) && $stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase
  import cdiv_pkg::*;
#(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_sh_i,
  input  logic [HI_W-1:0] hi_sh_i,
  input  logic [LO_W-1:0] lo_sh_i,
  output logic            act_en_o,
  output logic            lvl_o
);
  localparam int unsigned CNT_W = max2(HI_W, LO_W);

  logic             act_en_q;
  logic [HI_W-1:0]  act_hi_q;
  logic [LO_W-1:0]  act_lo_q;
  logic             lvl_d, lvl_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [CNT_W-1:0] hi_lim, lo_lim;
  logic             high_end, low_end, ld_en;

  assign hi_lim   = CNT_W'(act_hi_q);
  assign lo_lim   = CNT_W'(act_lo_q);
  assign high_end = act_en_q && lvl_q && (cnt_q == hi_lim);
  assign low_end  = act_en_q && !lvl_q && (cnt_q == lo_lim);
  // settings are adopted in bypass or at the end of a low phase
  assign ld_en    = !act_en_q || low_end;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (ld_en) begin
      lvl_d = en_sh_i;
      cnt_d = '0;
    end else if (high_end) begin
      lvl_d = 1'b0;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_q <= 1'b0;
      act_hi_q <= '0;
      act_lo_q <= '0;
    end else if (ld_en) begin
      act_en_q <= en_sh_i;
      act_hi_q <= hi_sh_i;
      act_lo_q <= lo_sh_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign act_en_o = act_en_q;
  assign lvl_o    = lvl_q;

  a_r2_bypass_level_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en_q |-> !lvl_q);
  a_r3_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en_q && lvl_q && cnt_q != hi_lim) |=> lvl_q);
  a_r3_high_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en_q && lvl_q && cnt_q == hi_lim) |=> !lvl_q);
  a_r4_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en_q && !lvl_q && cnt_q != lo_lim) |=> (!lvl_q && act_en_q));
  a_r6_settings_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en_q && !(!lvl_q && cnt_q == lo_lim)) |=>
      ($stable(act_hi_q) && $stable(act_lo_q) && act_en_q));
  a_r7_restart_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_en_q && en_sh_i) |=> (act_en_q && lvl_q && cnt_q == '0));
endmodule

// File: rtl/cdiv_outgate.sv
module cdiv_outgate #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_en_i,
  input  logic lvl_i,
  input  logic gate_sh_i,
  output logic clk_o
);
  logic gate_on;
  logic src;

  generate
    if (HAS_GATE) begin : g_gate
      logic gate_ce, gate_q;
      // only change the gate while the divided level is low
      assign gate_ce = !act_en_i || !lvl_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      gate_q <= 1'b0;
        else if (gate_ce) gate_q <= gate_sh_i;
      end
      assign gate_on = gate_q;

      a_r8_gate_frozen_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_en_i && lvl_i) |=> $stable(gate_q));
    end else begin : g_always_on
      logic unused_gate;
      assign unused_gate = gate_sh_i;
      assign gate_on     = 1'b1;
    end
  endgenerate

  assign src   = act_en_i ? lvl_i : clk_i;
  assign clk_o = gate_on & src;
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div
  import cdiv_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EN_POS   = 31,
  parameter int unsigned HI_POS   = 0,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned LO_POS   = 8,
  parameter int unsigned LO_W     = 6,
  parameter int unsigned GATE_POS = 0,
  parameter bit          HAS_GATE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              clk_o
);
  logic            en_sh, gate_sh, act_en, lvl;
  logic [HI_W-1:0] hi_sh;
  logic [LO_W-1:0] lo_sh;

  cdiv_regs #(
    .DATA_W(DATA_W), .EN_POS(EN_POS), .HI_POS(HI_POS), .HI_W(HI_W),
    .LO_POS(LO_POS), .LO_W(LO_W), .GATE_POS(GATE_POS), .HAS_GATE(HAS_GATE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .en_sh_o(en_sh), .hi_sh_o(hi_sh), .lo_sh_o(lo_sh),
    .gate_sh_o(gate_sh)
  );

  cdiv_phase #(.HI_W(HI_W), .LO_W(LO_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_sh_i(en_sh), .hi_sh_i(hi_sh),
    .lo_sh_i(lo_sh), .act_en_o(act_en), .lvl_o(lvl)
  );

  cdiv_outgate #(.HAS_GATE(HAS_GATE)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_en_i(act_en), .lvl_i(lvl),
    .gate_sh_i(gate_sh), .clk_o(clk_o)
  );

  // R1: straight after reset the output is held low
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni) && HAS_GATE) |-> !clk_o);
endmodule

// File: tb/phase_clk_div_tb_top.sv
`timescale 1ns/1ps
module phase_clk_div_tb_top;
  logic        clk, rst_n, wr_en, wr_sel;
  logic [31:0] wr_data;
  logic        clk_out, clk_out_ng;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic hs, ls, hs_ng, ls_ng;
  bit done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  phase_clk_div dut_i (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .clk_o(clk_out));
  phase_clk_div #(.HAS_GATE(1'b0)) dut_ng_i (.clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .clk_o(clk_out_ng));

  // behavioural reference: remaining-cycle countdown
  int m_en_sh, m_hi_sh, m_lo_sh, m_gate_sh, m_act_en, m_act_hi, m_act_lo;
  int m_lvl, m_left, m_gate;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en_sh = 0; m_hi_sh = 0; m_lo_sh = 0; m_gate_sh = 0;
      m_act_en = 0; m_act_hi = 0; m_act_lo = 0; m_lvl = 0; m_left = 0; m_gate = 0;
    end else begin
      if (m_act_en == 0 || m_lvl == 0) m_gate = m_gate_sh;
      if (m_act_en == 0 || (m_lvl == 0 && m_left == 0)) begin
        m_act_en = m_en_sh; m_act_hi = m_hi_sh; m_act_lo = m_lo_sh;
        m_lvl = m_en_sh; m_left = m_hi_sh;
      end else if (m_left == 0) begin
        m_lvl = 0; m_left = m_act_lo;
      end else m_left = m_left - 1;
      if (wr_en && !wr_sel) begin
        m_en_sh = int'(wr_data[31]); m_hi_sh = int'(wr_data[7:0]); m_lo_sh = int'(wr_data[13:8]);
      end else if (wr_en && wr_sel) m_gate_sh = int'(wr_data[0]);
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic e_hi, e_lo, n_hi, n_lo;
    @(posedge clk); #5;
    e_hi = (m_gate != 0) && (m_act_en != 0 ? m_lvl != 0 : 1'b1);
    e_lo = (m_gate != 0) && (m_act_en != 0) && (m_lvl != 0);
    n_hi = (m_act_en != 0) ? (m_lvl != 0) : 1'b1;
    n_lo = (m_act_en != 0) && (m_lvl != 0);
    hs = clk_out; hs_ng = clk_out_ng;
    if (rst_n) begin
      check(cur_req, hs, e_hi, "gated out, high half");
      check("R10", hs_ng, n_hi, "ungated out, high half");
    end
    #10;
    ls = clk_out; ls_ng = clk_out_ng;
    if (rst_n) begin
      check(cur_req, ls, e_lo, "gated out, low half");
      check("R10", ls_ng, n_lo, "ungated out, low half");
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic [31:0] ctrl(bit en, int hi, int lo);
    return {en, 17'd0, lo[5:0], hi[7:0]};
  endfunction

  task automatic wr(bit sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic measure(string req, int exp_hi, int exp_lo);
    int nh = 0, nl = 0;
    logic prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (!prev && hs) break;
      prev = hs;
    end
    while (hs) begin nh++; tick(); end
    while (!hs && nl < 2000) begin nl++; tick(); end
    checks++;
    if (nh != exp_hi || nl != exp_lo) begin
      errors++;
      $display("FAIL %s phase lengths: actual %0d/%0d expected %0d/%0d", req, nh, nl, exp_hi, exp_lo);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    ticks(3);
    rst_n = 1'b1;
    cur_req = "R1";
    ticks(4);
    check("R1", hs, 1'b0, "reset output high half");
    check("R10", hs_ng, 1'b1, "ungated bypass after reset");
    // R2: bypass ignores fields
    cur_req = "R2";
    wr(1'b0, ctrl(0, 5, 3));
    wr(1'b1, 32'h1);
    ticks(6);
    check("R2", hs, 1'b1, "bypass high half");
    check("R2", ls, 1'b0, "bypass low half");
    // R7 then R3/R4
    cur_req = "R7";
    wr(1'b0, ctrl(1, 2, 4));
    ticks(2);
    cur_req = "R3";
    measure("R3", 3, 5);
    measure("R4", 3, 5);
    // R9: gate write keeps settings
    cur_req = "R9";
    wr(1'b1, 32'h1);
    measure("R9", 3, 5);
    // R6: mid-phase reload
    cur_req = "R6";
    ticks(1);
    wr(1'b0, ctrl(1, 6, 1));
    ticks(12);
    measure("R6", 7, 2);
    // R5: divide by 2
    cur_req = "R5";
    wr(1'b0, ctrl(1, 0, 0));
    ticks(10);
    measure("R5", 1, 1);
    // R8: gate off/on while running
    cur_req = "R8";
    wr(1'b0, ctrl(1, 3, 2));
    ticks(10);
    wr(1'b1, 32'h0);
    ticks(12);
    check("R8", hs, 1'b0, "gated off output");
    wr(1'b1, 32'h1);
    ticks(5);
    measure("R8", 4, 3);
    // R11: disable returns to bypass after low phase
    cur_req = "R11";
    wr(1'b0, ctrl(0, 3, 2));
    ticks(10);
    check("R11", hs, 1'b1, "bypass high half after disable");
    check("R11", ls, 1'b0, "bypass low half after disable");
    // widest fields
    cur_req = "R3";
    wr(1'b0, ctrl(1, 255, 63));
    measure("R3", 256, 64);
    // R10: gate off again; ungated copy unaffected
    cur_req = "R10";
    wr(1'b1, 32'h0);
    ticks(400);
    ticks(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule